// File: doc/BRIEF.md
# Sensorless Boost Inductor Current Estimator

This block gives a running estimate of the inductor current in a boost power stage without a current sensor. On every clock it adds the inductor's volt-second change to an accumulator. The step is chosen by the switch gate state that the controller itself produces. With the switch conducting, the step is the input voltage. With the switch open, the step is the input voltage minus the output voltage. The step is multiplied by a programmable scale, which stands in for the clock period divided by the inductance. A signed trim constant is added to the conducting step to cancel volt-second errors from gate delays and offsets.

Both voltage samples come from slow converters that lag the real signal. For this reason each sample is predicted one step ahead by linear extrapolation before use. The prediction is twice the newest sample minus the one before it, limited to the unsigned sample range. The prediction history moves only when a sample strobe arrives.

The estimate is held at zero when it would go negative. This models the diode blocking in discontinuous conduction, so accumulated error is cleared near each line zero crossing. The estimate is also held at its full-scale value when it would overflow. A current-mode loop elsewhere compares the estimate with its carrier.

Top module: `ilest_top`

## Requirements
- R1: While rst_n is low, est_o is 0 and both extrapolation histories (newest and previous sample) are 0.
- R2: On each clock with gate_on_i=1, est_o increases by vin_x*scale_i + comp_i. Here vin_x is the extrapolated input voltage and comp_i is a two's-complement value.
- R3: On each clock with gate_on_i=0, est_o changes by (vin_x - vout_x)*scale_i, which is a decrease when vout_x > vin_x.
- R4: An update that would give a negative estimate sets est_o to 0.
- R5: An update that would exceed 2^AW-1 sets est_o to 2^AW-1.
- R6: A sample input whose strobe is low has no effect. The histories and the extrapolated value stay unchanged.
- R7: The extrapolated value is 2*newest - previous, using the two most recently strobed samples. Before any strobe both are 0.
- R8: The extrapolated value is limited to 0 at the low end and to 2^VW-1 at the high end.
- R9: est_o is a register that takes exactly one step per clock. The step uses the gate state at that edge and the extrapolated values from before that edge's strobe update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one estimator step per edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vin_smp_i | input | VW | Input voltage sample, unsigned |
| vin_stb_i | input | 1 | Input voltage sample strobe |
| vout_smp_i | input | VW | Output voltage sample, unsigned |
| vout_stb_i | input | 1 | Output voltage sample strobe |
| gate_on_i | input | 1 | Switch drive state, 1 = conducting |
| comp_i | input | CW | Signed volt-second trim added while conducting |
| scale_i | input | GW | Volt-second scale (multiplier, or shift count in shift mode) |
| est_o | output | AW | Unsigned current estimate |

## Verification
On every cycle, the assertions check several properties. The estimate never falls while the switch conducts with a non-negative trim. It never rises while the switch is open and the output prediction is at or above the input prediction. Once the estimate is at zero in that state, it stays there. The predictions hold without a strobe, and two equal consecutive strobed samples predict that same value. The exact step size needs the scenarios in the bench. These include the trim and scale products, the prediction wrapping below zero or past full scale, and the estimate reaching its ceiling. In these scenarios a behavioural model, with its own sample queues, is compared with est_o after every clock.

// File: rtl/ilest_pkg.sv
package ilest_pkg;
   typedef enum logic [0:0] {
      SCL_SHIFT = 1'b0,
      SCL_MULT  = 1'b1
   } scale_mode_e;
endpackage

// File: rtl/ilest_extrap.sv
module ilest_extrap #(
   parameter int VW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_i,
   input  logic [VW-1:0] smp_i,
   output logic [VW-1:0] x_o
);
   logic [VW-1:0]        newest_q;
   logic [VW-1:0]        older_q;
   logic signed [VW+1:0] lin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         newest_q <= '0;
         older_q  <= '0;
      end else if (stb_i) begin
         older_q  <= newest_q;
         newest_q <= smp_i;
      end
   end

   always_comb begin
      lin = ($signed({2'b00, newest_q}) <<< 1) - $signed({2'b00, older_q});
      if (lin[VW+1])
         x_o = '0;
      else if (lin[VW])
         x_o = '1;
      else
         x_o = lin[VW-1:0];
   end
endmodule

// File: rtl/ilest_step.sv
module ilest_step
   import ilest_pkg::*;
#(
   parameter int          VW   = 8,
   parameter int          GW   = 4,
   parameter int          CW   = 8,
   parameter int          SW   = 14,
   parameter scale_mode_e MODE = SCL_MULT
) (
   input  logic                 gate_on_i,
   input  logic [VW-1:0]        vin_x_i,
   input  logic [VW-1:0]        vout_x_i,
   input  logic [GW-1:0]        scale_i,
   input  logic signed [CW-1:0] comp_i,
   output logic signed [SW-1:0] step_o
);
   logic signed [VW:0]   raw;
   logic signed [SW-1:0] raw_e;
   logic signed [SW-1:0] scaled;
   logic signed [SW-1:0] comp_e;

   always_comb begin
      if (gate_on_i)
         raw = $signed({1'b0, vin_x_i});
      else
         raw = $signed({1'b0, vin_x_i}) - $signed({1'b0, vout_x_i});
      raw_e  = {{(SW-VW-1){raw[VW]}}, raw};
      comp_e = {{(SW-CW){comp_i[CW-1]}}, comp_i};
   end

   generate
      if (MODE == SCL_MULT) begin : g_mult
         logic signed [SW-1:0] scl_e;
         always_comb begin
            scl_e  = $signed({{(SW-GW){1'b0}}, scale_i});
            scaled = raw_e * scl_e;
         end
      end else begin : g_shift
         always_comb scaled = raw_e <<< scale_i;
      end
   endgenerate

   always_comb step_o = gate_on_i ? (scaled + comp_e) : scaled;
endmodule

// File: rtl/ilest_acc.sv
module ilest_acc #(
   parameter int AW = 16,
   parameter int SW = 14,
   parameter int NW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW-1:0] step_i,
   output logic [AW-1:0]        est_o
);
   logic signed [NW-1:0] sum;
   logic [AW-1:0]        nxt;

   always_comb begin
      sum = $signed({{(NW-AW){1'b0}}, est_o}) + $signed({{(NW-SW){step_i[SW-1]}}, step_i});
      if (sum[NW-1])
         nxt = '0;
      else if (|sum[NW-2:AW])
         nxt = '1;
      else
         nxt = sum[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         est_o <= '0;
      else
         est_o <= nxt;
   end
endmodule

// File: rtl/ilest_top.sv
module ilest_top
   import ilest_pkg::*;
#(
   parameter int          VW   = 8,
   parameter int          GW   = 4,
   parameter int          CW   = 8,
   parameter int          AW   = 16,
   parameter scale_mode_e MODE = SCL_MULT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VW-1:0]        vin_smp_i,
   input  logic                 vin_stb_i,
   input  logic [VW-1:0]        vout_smp_i,
   input  logic                 vout_stb_i,
   input  logic                 gate_on_i,
   input  logic signed [CW-1:0] comp_i,
   input  logic [GW-1:0]        scale_i,
   output logic [AW-1:0]        est_o
);
   localparam int PW = (MODE == SCL_MULT) ? (VW + GW + 2) : (VW + 1 + (1 << GW));
   localparam int SW = ((PW > CW) ? PW : CW) + 1;
   localparam int NW = ((SW > AW) ? SW : AW) + 2;

   generate
      if (VW < 2)  begin : g_bad_vw $error("VW must be at least 2"); end
      if (GW < 1)  begin : g_bad_gw $error("GW must be at least 1"); end
      if (CW < 2)  begin : g_bad_cw $error("CW must be at least 2"); end
      if (AW < VW) begin : g_bad_aw $error("AW must not be below VW"); end
   endgenerate

   logic [VW-1:0]        vin_x;
   logic [VW-1:0]        vout_x;
   logic signed [SW-1:0] step;

   ilest_extrap #(.VW(VW)) u_vin_xp (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_i (vin_stb_i),
      .smp_i (vin_smp_i),
      .x_o   (vin_x)
   );

   ilest_extrap #(.VW(VW)) u_vout_xp (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_i (vout_stb_i),
      .smp_i (vout_smp_i),
      .x_o   (vout_x)
   );

   ilest_step #(.VW(VW), .GW(GW), .CW(CW), .SW(SW), .MODE(MODE)) u_step (
      .gate_on_i (gate_on_i),
      .vin_x_i   (vin_x),
      .vout_x_i  (vout_x),
      .scale_i   (scale_i),
      .comp_i    (comp_i),
      .step_o    (step)
   );

   ilest_acc #(.AW(AW), .SW(SW), .NW(NW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .est_o  (est_o)
   );
endmodule

// File: rtl/ilest_chk.sv
module ilest_chk #(
   parameter int VW = 8,
   parameter int CW = 8,
   parameter int AW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 gate_on_i,
   input logic                 vin_stb_i,
   input logic [VW-1:0]        vin_smp_i,
   input logic signed [CW-1:0] comp_i,
   input logic [AW-1:0]        est_o,
   input logic [VW-1:0]        vin_x,
   input logic [VW-1:0]        vout_x
);
   AST_ON_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on_i && !comp_i[CW-1]) |=> (est_o >= $past(est_o))); // R2

   AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_on_i && (vin_x <= vout_x)) |=> (est_o <= $past(est_o))); // R3

   AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_on_i && (vin_x < vout_x) && (est_o == '0)) |=> (est_o == '0)); // R4

   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !vin_stb_i |=> $stable(vin_x)); // R6

   AST_FLAT_PREDICT: assert property (@(posedge clk) disable iff (!rst_n)
      (vin_stb_i && $past(vin_stb_i) && $past(rst_n) && (vin_smp_i == $past(vin_smp_i)))
      |=> (vin_x == $past(vin_smp_i))); // R7
endmodule

bind ilest_top ilest_chk #(.VW(VW), .CW(CW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gate_on_i (gate_on_i),
   .vin_stb_i (vin_stb_i),
   .vin_smp_i (vin_smp_i),
   .comp_i    (comp_i),
   .est_o     (est_o),
   .vin_x     (vin_x),
   .vout_x    (vout_x)
);

// File: tb/test_ilest_top.sv
module test_ilest_top;
   localparam int TCLK = 10;
   localparam int VW   = 8;
   localparam int GW   = 4;
   localparam int CW   = 8;
   localparam int AW   = 16;
   localparam int VMAX = (1 << VW) - 1;
   localparam int AMAX = (1 << AW) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [VW-1:0]        vin_smp = '0;
   logic                 vin_stb = 1'b0;
   logic [VW-1:0]        vout_smp = '0;
   logic                 vout_stb = 1'b0;
   logic                 gate_on = 1'b0;
   logic signed [CW-1:0] comp = '0;
   logic [GW-1:0]        scale = '0;
   logic [AW-1:0]        est;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int vin_q[$];
   int vout_q[$];
   int model_est = 0;

   always #(TCLK/2) clk = ~clk;

   ilest_top #(.VW(VW), .GW(GW), .CW(CW), .AW(AW)) i_ilest_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .vin_smp_i  (vin_smp),
      .vin_stb_i  (vin_stb),
      .vout_smp_i (vout_smp),
      .vout_stb_i (vout_stb),
      .gate_on_i  (gate_on),
      .comp_i     (comp),
      .scale_i    (scale),
      .est_o      (est)
   );

   function automatic int limit(int x, int hi);
      return (x < 0) ? 0 : ((x > hi) ? hi : x);
   endfunction

   function automatic int predict(ref int q[$]);
      return limit(2 * q[1] - q[0], VMAX);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s est=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(string req, bit g, int vs, bit vst, int os, bit ost, int cm, int sc);
      int px, ox, st;
      gate_on = g; vin_smp = VW'(vs); vin_stb = vst;
      vout_smp = VW'(os); vout_stb = ost; comp = CW'(cm); scale = GW'(sc);
      @(posedge clk);
      // R9: one step from pre-edge predictions, then history moves
      px = predict(vin_q);
      ox = predict(vout_q);
      st = g ? (px * sc + cm) : ((px - ox) * sc);
      model_est = limit(model_est + st, AMAX);
      if (vst) begin void'(vin_q.pop_front()); vin_q.push_back(vs); end
      if (ost) begin void'(vout_q.pop_front()); vout_q.push_back(os); end
      @(negedge clk);
      check(req, int'(est), model_est);
   endtask

   initial begin
      #(TCLK * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      vin_q = '{0, 0};
      vout_q = '{0, 0};
      repeat (3) @(negedge clk);
      check("R1 reset", int'(est), 0);
      rst_n = 1'b1;
      // R7: two equal strobes predict that value; open switch with vout>vin
      cyc("R7", 0, 100, 1, 200, 1, 0, 1);
      cyc("R7", 0, 100, 1, 200, 1, 0, 1);
      // R2: conducting, +100 per clock
      for (int i = 0; i < 10; i++) cyc("R2", 1, 100, 0, 200, 0, 0, 1);
      // R2: trim and scale
      for (int i = 0; i < 5; i++) cyc("R2 trim", 1, 100, 0, 200, 0, -3, 2);
      // R3 then R4: falling, held at zero
      for (int i = 0; i < 20; i++) cyc("R3/R4", 0, 100, 0, 200, 0, 0, 1);
      check("R4 floor", int'(est), 0);
      // R6: samples without strobe ignored
      for (int i = 0; i < 5; i++) cyc("R6", 1, 30, 0, 5, 0, 0, 1);
      check("R6 slope", int'(est), 500);
      // R8 low: 2*50-200 < 0 -> 0
      cyc("R8 low", 0, 200, 1, 200, 0, 0, 0);
      cyc("R8 low", 0, 50, 1, 200, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R8 low", 1, 50, 0, 200, 0, 0, 3);
      check("R8 low hold", int'(est), 500);
      // R8 high: 2*250-100 -> 255
      cyc("R8 high", 0, 100, 1, 200, 0, 0, 0);
      cyc("R8 high", 0, 250, 1, 200, 0, 0, 0);
      cyc("R8 high", 1, 250, 0, 200, 0, 0, 1);
      check("R8 high step", int'(est), 755);
      // R9: alternating gate each clock
      for (int i = 0; i < 20; i++) cyc("R9", (i % 2) == 0, 250, 0, 200, 0, 4, 3);
      // R5: ceiling
      cyc("R5", 1, 255, 1, 200, 0, 0, 15);
      cyc("R5", 1, 255, 1, 200, 0, 0, 15);
      for (int i = 0; i < 25; i++) cyc("R5", 1, 255, 0, 200, 0, 100, 15);
      check("R5 ceiling", int'(est), AMAX);
      // R1: reset mid-run clears estimate
      rst_n = 1'b0;
      vin_q = '{0, 0};
      vout_q = '{0, 0};
      model_est = 0;
      @(negedge clk);
      check("R1 rerun", int'(est), 0);
      rst_n = 1'b1;
      cyc("R1 history", 1, 40, 0, 0, 0, 0, 1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule